// File: doc/BRIEF.md
# Debounced Key Capture with Two-Digit History

This block sits behind a matrix keypad scanner. The scanner supplies a raw key-held flag and a 4-bit code for the key it has found. The block accepts a press only when the flag stays high for a programmable number of clock cycles. Bounces and short glitches are dropped. Each accepted press produces one single-cycle strobe, and the key code stays steady alongside it.

The press filter is a four-state machine. Its states are idle, counting, firing and waiting-for-release. A key that stays held does not fire again. The block fires again only after the flag has been seen low. The strobe also drives a two-digit history register, which shifts the newest code in and moves the previous digit to the older position. A display stage can use this register directly.

Top module: `key_capture`

## Requirements
- R1: While `rst_n` is low, `fire` is 0 and `digit_new` and `digit_old` are both 0.
- R2: A press is accepted only if `key_down` is sampled high on THRESH+1 consecutive rising edges, starting from idle. Shorter high runs never raise `fire`.
- R3: If `key_down` is sampled low before the run completes, the count is discarded. The next high sample starts a fresh run of THRESH+1 edges.
- R4: `fire` rises in the cycle after the edge that completes the run, and it is high for exactly one cycle per accepted press.
- R5: `fire_code` equals the `key_code` sampled on the first edge of the accepted run. It holds that value through the fire cycle, even if `key_code` changes while the key is held.
- R6: After a fire, `fire` stays low for as long as `key_down` remains high. A new run may start only after `key_down` has been sampled low at least once.
- R7: On each edge where `fire` is high, `digit_old` takes the value of `digit_new`, and `digit_new` takes the value of `fire_code`. At all other times both digits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_down | input | 1 | Raw key-held flag from the scanner, synchronous to clk |
| key_code | input | 4 | Code of the key the scanner found |
| fire | output | 1 | One-cycle strobe for each accepted press |
| fire_code | output | 4 | Key code captured at the start of the accepted press |
| digit_new | output | 4 | Most recent accepted key |
| digit_old | output | 4 | Accepted key before the most recent one |

## Verification
The assertions check the following on every cycle:
- `fire` never lasts two cycles.
- A rising `fire` always follows a counting cycle in which the key was still held.
- A drop during counting returns the machine to idle.
- A held key in the release-wait state cannot fire.
- Every fire shifts the history register correctly.

Some behaviour only the bench scenarios can show:
- A run of exactly THRESH high samples is rejected, and a run of THRESH+1 is accepted.
- A code change in the middle of a press does not leak into the captured code.
- A long hold produces only one digit.

These cases are compared cycle by cycle against a run-length model in the bench.

// File: rtl/key_capture.sv
module key_capture #(
  parameter int CLK_HZ    = 200_000_000,
  parameter int SETTLE_US = 20_000,
  parameter int THRESH    = (CLK_HZ / 1_000_000) * SETTLE_US
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_down,
  input  logic [3:0] key_code,
  output logic       fire,
  output logic [3:0] fire_code,
  output logic [3:0] digit_new,
  output logic [3:0] digit_old
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_EMIT, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      cap <= '0;
    end else begin
      case (st)
        S_IDLE: if (key_down) begin
          st  <= S_COUNT;
          cnt <= '0;
          cap <= key_code;
        end
        S_COUNT: if (!key_down) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else if (cnt == LAST) begin
          st  <= S_EMIT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_EMIT:  st <= S_HOLD;
        default: if (!key_down) st <= S_IDLE;
      endcase
    end
  end

  assign fire      = (st == S_EMIT);
  assign fire_code = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_new <= '0;
      digit_old <= '0;
    end else if (fire) begin
      digit_old <= digit_new;
      digit_new <= cap;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R4
  AST_FIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire) |-> ($past(st) == S_COUNT && $past(key_down))); // R2
  AST_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COUNT && !key_down) |=> (st == S_IDLE && !fire)); // R3
  AST_HELD_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && key_down) |=> !fire); // R6
  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COUNT) |=> $stable(fire_code)); // R5
  AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (digit_old == $past(digit_new) && digit_new == $past(fire_code))); // R7
  AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(digit_new) && $stable(digit_old))); // R7
endmodule

// File: tb/tb_key_capture.sv
module tb_key_capture;
  localparam int TH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_down = 1'b0;
  logic [3:0] key_code = 4'h0;
  logic       fire;
  logic [3:0] fire_code, digit_new, digit_old;

  int n_chk = 0, n_bad = 0, fires = 0;
  bit comparing = 1'b0, done = 1'b0;

  // behavioural model
  int       m_run = 0;
  bit       m_lock = 1'b0, m_fire = 1'b0;
  bit [3:0] m_code = 4'h0, m_new = 4'h0, m_old = 4'h0;

  always #2.5 clk = ~clk;

  key_capture #(.THRESH(TH)) dut (
    .clk(clk), .rst_n(rst_n), .key_down(key_down), .key_code(key_code),
    .fire(fire), .fire_code(fire_code), .digit_new(digit_new), .digit_old(digit_old)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_lock = 0; m_fire = 0; m_code = 0; m_new = 0; m_old = 0;
    end else begin
      if (m_fire) begin
        m_old = m_new;
        m_new = m_code;
        m_fire = 0;
        m_lock = 1;
      end else if (m_lock) begin
        if (!key_down) m_lock = 0;
      end else if (key_down) begin
        m_run++;
        if (m_run == 1) m_code = key_code;
        if (m_run == TH + 1) begin
          m_fire = 1;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      check(fire == m_fire, "R2/R3/R4/R6 fire", fire, m_fire);
      if (m_fire) check(fire_code == m_code, "R5 fire_code", fire_code, m_code);
      check(digit_new == m_new, "R7 digit_new", digit_new, m_new);
      check(digit_old == m_old, "R7 digit_old", digit_old, m_old);
      if (fire) fires++;
    end
  end

  task automatic press(input bit [3:0] code, input int n);
    @(negedge clk);
    key_down = 1'b1;
    key_code = code;
    repeat (n) @(negedge clk);
    key_down = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    gap(3);
    check(fire == 1'b0, "R1 fire in reset", fire, 0);
    check(digit_new == 4'h0 && digit_old == 4'h0, "R1 digits in reset",
          {digit_old, digit_new}, 0);
    rst_n = 1'b1;
    comparing = 1'b1;
    gap(2);

    press(4'h7, 2); gap(3);
    press(4'h7, TH); gap(3);
    check(fires == 0, "R2 short runs rejected", fires, 0);

    @(negedge clk);
    key_down = 1'b1; key_code = 4'h9;
    gap(TH - 1);
    key_down = 1'b0; gap(1);
    key_down = 1'b1; key_code = 4'hA;
    gap(TH + 1);
    key_code = 4'h3;
    gap(20);
    key_down = 1'b0;
    gap(3);
    check(fires == 1, "R3/R6 one fire after restart and long hold", fires, 1);
    check(digit_new == 4'hA, "R5 captured first code of run", digit_new, 4'hA);

    press(4'h5, TH + 1); gap(3);
    check(fires == 2, "R4 exact-length run accepted", fires, 2);
    press(4'hC, TH + 6); gap(4);
    check(digit_new == 4'hC && digit_old == 4'h5, "R7 history shift",
          {digit_old, digit_new}, 8'h5C);

    @(negedge clk);
    key_down = 1'b1; key_code = 4'h1;
    gap(TH + 3);
    key_code = 4'h2;
    gap(1); key_down = 1'b0; gap(1); key_down = 1'b1;
    gap(TH + 3);
    key_down = 1'b0;
    gap(3);
    check(fires == 5, "R6 re-arm after one low sample", fires, 5);
    check(digit_new == 4'h2 && digit_old == 4'h1, "R7 back-to-back presses",
          {digit_old, digit_new}, 8'h12);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule